// File: doc/BRIEF.md
# Processor Status Trace Port

This block drives a parallel real-time trace port made of two 4-bit nibbles. Each clock cycle it updates a status nibble and a debug data nibble. The status nibble carries the status code that the core reports for its pipeline. The debug data nibble carries one of two things. It normally shows the register breakpoint status. When a capture is taken, it shows a 32-bit captured address or operand, sent one nibble per cycle. The port samples its inputs at one clock edge and presents them after that edge. An external probe reads both nibbles every cycle.

The block also handles a manual breakpoint request. The request is held as pending until the core retires an instruction. The core then enters the halted state and the status nibble reads 0xF. The halted state lasts until a resume pulse arrives. The capture input is a stream. A capture is taken when `cap_valid` is high and either `cap_wdd` (an explicit write-debug-data request) or the configuration bit `cfg_capture_en` is set. The `cap_ready` output reports whether the current capture would be stored. The producer is not required to wait for it. A taken capture presented while `cap_ready` is low is discarded, and the sticky `overflow` flag is set. One word can wait in a one-entry buffer behind the word being sent.

Top module: `trace_port`

## Requirements
- R1: After reset, `pst` and `ddata` are 0x0, `halted` and `overflow` are 0, and `cap_ready` is 1.
- R2: While not halted, `pst` shows the `core_status` value sampled at the previous clock edge. Capture traffic has no effect on `pst`.
- R3: A `brk_req` pulse is held pending. The core halts at the first edge where `retire` is high, either on or after the request edge. Without `retire` the core never halts. From that edge on, `halted` is 1 and `pst` is 0xF.
- R4: While halted, `pst` stays 0xF and `halted` stays 1 until an edge with `resume` high. After that edge, `pst` returns to `core_status`. A `brk_req` while halted is dropped, and a `resume` while running has no effect.
- R5: When no word is being sent, `ddata` shows the `bp_status` value sampled at the previous edge.
- R6: Take a capture at edge k. The eight nibbles of `cap_data` appear on `ddata` after edges k+1 through k+8, least significant nibble first. After that, `bp_status` returns, unless another word is waiting.
- R7: With `cfg_capture_en` low, a capture that has `cap_wdd` low is ignored, and `ddata` keeps showing `bp_status`. A capture with `cap_wdd` high is taken whatever the value of `cfg_capture_en`.
- R8: A capture taken while a word is being sent goes into the one-entry buffer. Its first nibble follows the last nibble of the current word in the very next cycle.
- R9: `cap_ready` is low only when the buffer is full and the current word is not on its last nibble. A taken capture presented while `cap_ready` is low is discarded, and `overflow` becomes 1 after that edge. `overflow` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_status | input | 4 | Pipeline status code from the core |
| retire | input | 1 | Instruction retired this cycle |
| brk_req | input | 1 | Manual breakpoint request |
| resume | input | 1 | Leave the halted state |
| bp_status | input | 4 | Register breakpoint status |
| cfg_capture_en | input | 1 | Enable capture of address and operand values |
| cap_valid | input | 1 | Capture word present |
| cap_wdd | input | 1 | Explicit write-debug-data capture, taken regardless of configuration |
| cap_data | input | 32 | Captured address or operand |
| cap_ready | output | 1 | A taken capture would be stored |
| pst | output | 4 | Status nibble |
| ddata | output | 4 | Debug data nibble |
| halted | output | 1 | Core held in the halted state |
| overflow | output | 1 | Sticky flag: a capture was discarded |

## Verification
A wrong nibble counter or shift register shows up on `ddata` within eight cycles of a capture. It appears as a nibble that is out of order, repeated or missing, or as a word that cuts in too early or too late. A buffer slot that stays full or empty when it should not shows up in the same cycle, through `cap_ready`. After the last nibble of the current word, it also shows up either as a missing word or as `overflow` set when it should not be. A wrong pending or halt flag changes `pst` and `halted` at the edge right after the retire or resume that should have moved it.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int NIB_W = 4;
  typedef logic [NIB_W-1:0] nib_t;
  localparam nib_t HALT_CODE  = 4'hF;
  localparam nib_t RESET_CODE = 4'h0;
endpackage

// File: rtl/trace_halt_ctl.sv
module trace_halt_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_req,
  input  logic retire,
  input  logic resume,
  output logic halted,
  output logic halt_next
);
  logic pend_q, halt_q, trig;

  assign trig      = retire && (pend_q || brk_req);
  assign halt_next = halt_q ? !resume : trig;
  assign halted    = halt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      halt_q <= halt_next;
      if (halt_q || trig) pend_q <= 1'b0;
      else                pend_q <= pend_q | brk_req;
    end
  end

  // R4: the halted state holds until resume is pulsed
  assert_halt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !resume) |=> halt_q);
  // R3: the halted state is never entered without a retire
  assert_halt_needs_retire_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_q && !retire) |=> !halt_q);
endmodule

// File: rtl/trace_nibble_emitter.sv
module trace_nibble_emitter
  import trace_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [DATA_W-1:0] data,
  output logic              ready,
  output logic              overflow,
  output logic              active,
  output nib_t              nib
);
  localparam int NIBS  = DATA_W / NIB_W;
  localparam int IDX_W = (NIBS > 1) ? $clog2(NIBS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NIBS - 1);

  logic              busy_q, bv_q, ovf_q;
  logic [DATA_W-1:0] sh_q, bd_q;
  logic [IDX_W-1:0]  idx_q;
  logic              at_last, slot_free;

  assign at_last   = busy_q && (idx_q == LAST);
  assign slot_free = !busy_q || (at_last && !bv_q);
  assign ready     = !busy_q || !bv_q || at_last;
  assign overflow  = ovf_q;
  assign active    = busy_q;
  assign nib       = sh_q[NIB_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      bv_q   <= 1'b0;
      ovf_q  <= 1'b0;
      sh_q   <= '0;
      bd_q   <= '0;
      idx_q  <= '0;
    end else begin
      if (busy_q) begin
        if (at_last) begin
          if (bv_q) begin
            sh_q  <= bd_q;
            idx_q <= '0;
            bv_q  <= 1'b0;
          end else begin
            busy_q <= 1'b0;
          end
        end else begin
          sh_q  <= sh_q >> NIB_W;
          idx_q <= idx_q + 1'b1;
        end
      end
      if (take) begin
        if (slot_free) begin
          busy_q <= 1'b1;
          sh_q   <= data;
          idx_q  <= '0;
        end else if (ready) begin
          bv_q <= 1'b1;
          bd_q <= data;
        end else begin
          ovf_q <= 1'b1;
        end
      end
    end
  end

  // R9: overflow is sticky
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  // R9: a capture taken while not ready raises overflow
  assert_drop_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !ready) |=> ovf_q);
  // R8: a buffered word starts right after the last nibble
  assert_buf_drains_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (at_last && bv_q) |=> (busy_q && idx_q == '0));
endmodule

// File: rtl/trace_port.sv
module trace_port
  import trace_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        core_status,
  input  logic              retire,
  input  logic              brk_req,
  input  logic              resume,
  input  logic [3:0]        bp_status,
  input  logic              cfg_capture_en,
  input  logic              cap_valid,
  input  logic              cap_wdd,
  input  logic [DATA_W-1:0] cap_data,
  output logic              cap_ready,
  output logic [3:0]        pst,
  output logic [3:0]        ddata,
  output logic              halted,
  output logic              overflow
);
  logic halt_next, take, emit_active;
  nib_t emit_nib, pst_q, dd_q;

  assign take = cap_valid && (cap_wdd || cfg_capture_en);

  trace_halt_ctl u_halt (
    .clk       (clk),
    .rst_n     (rst_n),
    .brk_req   (brk_req),
    .retire    (retire),
    .resume    (resume),
    .halted    (halted),
    .halt_next (halt_next)
  );

  trace_nibble_emitter #(.DATA_W(DATA_W)) u_emit (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .data     (cap_data),
    .ready    (cap_ready),
    .overflow (overflow),
    .active   (emit_active),
    .nib      (emit_nib)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pst_q <= RESET_CODE;
      dd_q  <= RESET_CODE;
    end else begin
      pst_q <= halt_next ? HALT_CODE : core_status;
      dd_q  <= emit_active ? emit_nib : bp_status;
    end
  end

  assign pst   = pst_q;
  assign ddata = dd_q;

  // R4: while halted the status nibble reads the halt code
  assert_halt_pst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (pst == HALT_CODE));
endmodule

// File: tb/tb_trace_port.sv
module tb_trace_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  core_status = '0, bp_status = '0;
  logic        retire = 0, brk_req = 0, resume = 0;
  logic        cfg_capture_en = 0, cap_valid = 0, cap_wdd = 0;
  logic [31:0] cap_data = '0;
  logic        cap_ready, halted, overflow;
  logic [3:0]  pst, ddata;

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  bit m_h, m_p, m_b, m_bv, m_ovf;
  logic [31:0] m_sh, m_bd;
  int m_idx;
  logic [3:0] e_pst, e_dd;

  always #5 clk = ~clk;

  trace_port dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit m_ready();
    return !m_b || !m_bv || (m_idx == 7);
  endfunction

  task automatic m_reset();
    m_h = 0; m_p = 0; m_b = 0; m_bv = 0; m_ovf = 0;
    m_sh = '0; m_bd = '0; m_idx = 0; e_pst = 0; e_dd = 0;
  endtask

  // one clock: inputs are already driven; compute expectations, clock, compare
  task automatic step(input string tag);
    bit take, trig, hn, slot_free, rdy;
    take = cap_valid && (cap_wdd || cfg_capture_en);
    rdy  = m_ready();
    chk({tag, " R9 cap_ready"}, cap_ready, rdy);
    trig = retire && (m_p || brk_req);
    hn   = m_h ? !resume : trig;
    e_pst = hn ? 4'hF : core_status;
    e_dd  = m_b ? m_sh[3:0] : bp_status;
    slot_free = !m_b || (m_idx == 7 && !m_bv);
    m_p = (m_h || trig) ? 1'b0 : (m_p | brk_req);
    m_h = hn;
    if (m_b) begin
      if (m_idx == 7) begin
        if (m_bv) begin m_sh = m_bd; m_idx = 0; m_bv = 0; end
        else m_b = 0;
      end else begin
        m_sh = m_sh >> 4; m_idx++;
      end
    end
    if (take) begin
      if (slot_free) begin m_b = 1; m_sh = cap_data; m_idx = 0; end
      else if (rdy) begin m_bv = 1; m_bd = cap_data; end
      else m_ovf = 1;
    end
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R2/R4 pst"}, pst, e_pst);
    chk({tag, " R3/R4 halted"}, halted, m_h);
    chk({tag, " R5/R6 ddata"}, ddata, e_dd);
    chk({tag, " R9 overflow"}, overflow, m_ovf);
  endtask

  task automatic idle_inputs();
    retire = 0; brk_req = 0; resume = 0; cap_valid = 0; cap_wdd = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_reset();
    repeat (3) @(negedge clk);
    @(posedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 pst", pst, 4'h0);
    chk("R1 ddata", ddata, 4'h0);
    chk("R1 halted", halted, 1'b0);
    chk("R1 overflow", overflow, 1'b0);
    chk("R1 cap_ready", cap_ready, 1'b1);
    rst_n = 1;

    // R5: idle shows breakpoint status
    bp_status = 4'hA; core_status = 4'h3;
    step("R5 idle");
    chk("R5 ddata direct", ddata, 4'hA);
    chk("R2 pst direct", pst, 4'h3);

    // R7: capture ignored with configuration off and no write-debug-data
    cap_valid = 1; cap_data = 32'hDEADBEEF; bp_status = 4'h5;
    step("R7 ignored");
    cap_valid = 0;
    step("R7 ignored after");
    chk("R7 ddata still bp", ddata, 4'h5);

    // R6: capture with configuration on, nibbles least significant first
    cfg_capture_en = 1; cap_valid = 1; cap_data = 32'h87654321; bp_status = 4'h0;
    step("R6 take");
    cap_valid = 0;
    for (int i = 0; i < 8; i++) begin
      step("R6 emit");
      chk("R6 nibble order", ddata, 32'(i + 1));
    end
    bp_status = 4'hC;
    step("R6 back to bp");
    step("R6 back to bp 2");
    chk("R6 bp after word", ddata, 4'hC);

    // R8 + R9: two queued, third dropped; write-debug-data with config off (R7)
    cfg_capture_en = 0; cap_wdd = 1; cap_valid = 1; cap_data = 32'h11111111;
    step("R7 wdd take");
    cap_data = 32'h22222222;
    step("R8 buffer");
    cap_data = 32'h33333333;
    step("R9 drop");
    chk("R9 overflow set", overflow, 1'b1);
    idle_inputs();
    repeat (6) step("R8 drain");
    chk("R8 last of first word", ddata, 4'h1);
    step("R8 drain");
    chk("R8 no gap second word", ddata, 4'h2);
    repeat (8) step("R8 finish");

    // R3/R4 directed: breakpoint waits for retire, then resume
    brk_req = 1; core_status = 4'h6;
    step("R3 request");
    brk_req = 0;
    step("R3 pending");
    chk("R3 not halted before retire", halted, 1'b0);
    retire = 1;
    step("R3 retire");
    retire = 0;
    chk("R3 halted pst", pst, 4'hF);
    step("R4 hold");
    chk("R4 pst held", pst, 4'hF);
    resume = 1;
    step("R4 resume");
    resume = 0;
    chk("R4 resumed pst", pst, 4'h6);
    resume = 1;
    step("R4 resume while running");
    resume = 0;

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      core_status = 4'($urandom);
      bp_status   = 4'($urandom);
      retire      = ($urandom % 100) < 30;
      brk_req     = ($urandom % 100) < 4;
      resume      = ($urandom % 100) < 8;
      cap_valid   = ($urandom % 100) < 25;
      cap_wdd     = ($urandom % 100) < 30;
      cap_data    = $urandom;
      if (($urandom % 100) < 3) cfg_capture_en = !cfg_capture_en;
      step("rand");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule